// File: doc/BRIEF.md
# Power Management Event Window and Interrupt Logic

This block is the event side of a power-management function. Its 64-byte register window sits in I/O space at a base address that software places through a 32-bit configuration register. A separate configuration enable bit switches the window on or off, and the window is off after reset. Inside the window are four registers: a 16-bit event status register that software clears by writing ones, a 16-bit event enable register, a 16-bit control register, and a free-running timer.

Four hardware event sources can raise the level-sensitive system control interrupt: timer overflow, global lock, power button and real-time-clock alarm. A pending source drives the interrupt only while its enable bit is also set. The block also produces an arm signal that tells a timer scheduler when an overflow event is worth waiting for. A few read-only configuration bytes show fixed identification values and the base of a companion serial-bus controller, which is a build parameter.

Top module: `pm_evt_win`

## Requirements
- R1: After reset, configuration dword 0x40 and byte 0x80 read 0, the window does not decode, the status and enable registers are 0, the timer is 0, and `sci` and `tmr_arm` are low.
- R2: Configuration bytes 0x40..0x43 hold a 32-bit value (little-endian) that reads back as written. The window base is this value ANDed with 0xFFC0. `io_hit` is high exactly when `io_addr[15:6]` equals the base bits [15:6] and the window is enabled.
- R3: The window decodes only while bit 0 of configuration byte 0x80 is 1. While it is 0, `io_hit` is low, `io_rdata` is 0 and I/O writes change no register. Bits 7:1 of byte 0x80 read 0.
- R4: The status register is at window offset 0x00. An input pulse sets its bit: `ev_glock` sets bit 5, `ev_pwrbtn` sets bit 8, `ev_rtc` sets bit 10. Every bit other than 0, 5, 8 and 10 reads 0.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear hit the same bit in one cycle, the bit stays set.
- R6: The enable register is at window offset 0x02. It reads and writes bits 0, 5, 8 and 10 (mask 0x0521), and every other bit reads 0.
- R7: `sci` is high exactly when status AND enable is non-zero in bit 0, 5, 8 or 10. It follows the registered values, so it falls in the cycle after the write that clears the last such bit.
- R8: The timer is a TMR_BITS-wide up-counter that advances by one on each cycle with `tmr_tick` high. It reads zero-extended at window offset 0x08, and writes to it are ignored.
- R9: Status bit 0 sets whenever timer bit TMR_BITS-1 changes value, on both the rising and the falling change.
- R10: `tmr_arm` is high exactly when enable bit 0 is 1 and status bit 0 is 0.
- R11: The control register at window offset 0x04 stores all 16 written bits and reads them back.
- R12: Configuration byte 0x48 reads 0x01, bytes 0x49..0x4B read 0x00, and byte 0xD2 reads 0x90. Byte 0x90 reads (SMB_BASE & 0xF0) | 1 and byte 0x91 reads SMB_BASE[15:8]. Writes to these bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| io_wr | input | 1 | I/O 16-bit write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | I/O read data for `io_addr`, 0 outside the window |
| io_hit | output | 1 | `io_addr` falls inside the enabled window |
| tmr_tick | input | 1 | Timer advance strobe |
| ev_rtc | input | 1 | Real-time-clock alarm event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_glock | input | 1 | Global lock release event pulse |
| sci | output | 1 | Level system control interrupt |
| tmr_arm | output | 1 | Timer overflow event worth scheduling |

## Verification
The interrupt equation is driven by a table of event and enable combinations. The table covers a pending source that matches its enable, a pending source that has only a different source enabled, several sources at once, and an enable value that sets only unimplemented bits. Together these separate the real AND-of-four rule from a plain OR of status bits, from a wrong bit position, and from an enable mask that lets extra bits through. Directed cases follow for the single-cycle fall of the interrupt after a clearing write, set winning over clear, an unchanged status after a zero write, and the window base masking and enable gating. The timer is run to both changes of its top bit, so an overflow detector that sees only one direction, or that fires a cycle late, is caught.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
    // Status / enable bit positions
    localparam int BIT_TMR = 0;
    localparam int BIT_GLK = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;
    localparam logic [15:0] EVT_MASK = 16'h0521;

    // Window offsets
    localparam logic [5:0] OFS_STS = 6'h00;
    localparam logic [5:0] OFS_EN  = 6'h02;
    localparam logic [5:0] OFS_CTL = 6'h04;
    localparam logic [5:0] OFS_TMR = 6'h08;

    // Configuration byte addresses
    localparam logic [7:0] CFG_WINBASE = 8'h40;
    localparam logic [7:0] CFG_WINEN   = 8'h80;
    localparam logic [7:0] CFG_AUXBASE = 8'h48;
    localparam logic [7:0] CFG_SMB_LO  = 8'h90;
    localparam logic [7:0] CFG_SMB_HI  = 8'h91;
    localparam logic [7:0] CFG_SMB_CFG = 8'hD2;
    localparam logic [7:0] AUX_RESET   = 8'h01;
    localparam logic [7:0] SMB_CFG_VAL = 8'h90;

    typedef struct packed {
        logic [31:0] base;
        logic        en;
    } cfg_state_t;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_evt_pkg::*;
#(
    parameter logic [15:0] SMB_BASE = 16'hEEE0,
    parameter int          WIN_AW   = 6,
    localparam int         HI_W     = 16 - WIN_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [7:0]      cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata,
    output logic [HI_W-1:0] win_base_hi,
    output logic            win_en
);
    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            if (cfg_addr[7:2] == CFG_WINBASE[7:2])
                state_d.base[{cfg_addr[1:0], 3'b000} +: 8] = cfg_wdata;
            else if (cfg_addr == CFG_WINEN)
                state_d.en = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr[7:2] == CFG_WINBASE[7:2]) begin
            cfg_rdata = state_q.base[{cfg_addr[1:0], 3'b000} +: 8];
        end else begin
            case (cfg_addr)
                CFG_WINEN:   cfg_rdata = {7'b0, state_q.en};
                CFG_AUXBASE: cfg_rdata = AUX_RESET;
                CFG_SMB_LO:  cfg_rdata = {SMB_BASE[7:4], 4'h1};
                CFG_SMB_HI:  cfg_rdata = SMB_BASE[15:8];
                CFG_SMB_CFG: cfg_rdata = SMB_CFG_VAL;
                default:     cfg_rdata = '0;
            endcase
        end
    end

    assign win_base_hi = state_q.base[15:WIN_AW];
    assign win_en      = state_q.en;
endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
    parameter int  WIN_AW = 6,
    localparam int HI_W   = 16 - WIN_AW
) (
    input  logic [15:0]       io_addr,
    input  logic [HI_W-1:0]   win_base_hi,
    input  logic              win_en,
    output logic              hit,
    output logic [WIN_AW-1:0] ofs
);
    assign hit = win_en && (io_addr[15:WIN_AW] == win_base_hi);
    assign ofs = io_addr[WIN_AW-1:0];
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int TMR_BITS = 24,
    parameter int WIN_AW   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [WIN_AW-1:0]   ofs,
    input  logic [15:0]         wdata,
    input  logic                tmr_tick,
    input  logic                ev_rtc,
    input  logic                ev_pwrbtn,
    input  logic                ev_glock,
    output logic [15:0]         sts,
    output logic [15:0]         en,
    output logic [15:0]         ctl,
    output logic [TMR_BITS-1:0] tmr
);
    localparam int MSB = TMR_BITS - 1;

    typedef struct packed {
        logic [15:0]         sts;
        logic [15:0]         en;
        logic [15:0]         ctl;
        logic [TMR_BITS-1:0] tmr;
    } evt_state_t;

    evt_state_t state_d, state_q;
    logic       msb_flip;

    always_comb begin
        state_d  = state_q;
        msb_flip = 1'b0;
        if (tmr_tick) begin
            state_d.tmr = state_q.tmr + 1'b1;
            msb_flip    = state_d.tmr[MSB] ^ state_q.tmr[MSB];
        end
        if (wr) begin
            case (ofs)
                WIN_AW'(OFS_STS): state_d.sts = state_q.sts & ~(wdata & EVT_MASK);
                WIN_AW'(OFS_EN):  state_d.en  = wdata & EVT_MASK;
                WIN_AW'(OFS_CTL): state_d.ctl = wdata;
                default: ;
            endcase
        end
        // Sets applied last so they win over a same-cycle clear
        if (msb_flip)  state_d.sts[BIT_TMR] = 1'b1;
        if (ev_glock)  state_d.sts[BIT_GLK] = 1'b1;
        if (ev_pwrbtn) state_d.sts[BIT_PWR] = 1'b1;
        if (ev_rtc)    state_d.sts[BIT_RTC] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sts = state_q.sts;
    assign en  = state_q.en;
    assign ctl = state_q.ctl;
    assign tmr = state_q.tmr;
endmodule

// File: rtl/pm_evt_win.sv
module pm_evt_win
    import pm_evt_pkg::*;
#(
    parameter int          WIN_BYTES = 64,
    parameter int          TMR_BITS  = 24,
    parameter logic [15:0] SMB_BASE  = 16'hEEE0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic        io_wr,
    input  logic [15:0] io_addr,
    input  logic [15:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_hit,
    input  logic        tmr_tick,
    input  logic        ev_rtc,
    input  logic        ev_pwrbtn,
    input  logic        ev_glock,
    output logic        sci,
    output logic        tmr_arm
);
    localparam int WIN_AW = $clog2(WIN_BYTES);
    localparam int HI_W   = 16 - WIN_AW;

    logic [HI_W-1:0]     win_base_hi_w;
    logic                win_en_w;
    logic [WIN_AW-1:0]   ofs_w;
    logic [15:0]         sts_w, en_w, ctl_w;
    logic [TMR_BITS-1:0] tmr_w;

    pm_cfg_regs #(.SMB_BASE(SMB_BASE), .WIN_AW(WIN_AW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .win_base_hi(win_base_hi_w),
        .win_en     (win_en_w)
    );

    pm_win_decode #(.WIN_AW(WIN_AW)) u_dec (
        .io_addr    (io_addr),
        .win_base_hi(win_base_hi_w),
        .win_en     (win_en_w),
        .hit        (io_hit),
        .ofs        (ofs_w)
    );

    pm_evt_regs #(.TMR_BITS(TMR_BITS), .WIN_AW(WIN_AW)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (io_wr && io_hit),
        .ofs      (ofs_w),
        .wdata    (io_wdata),
        .tmr_tick (tmr_tick),
        .ev_rtc   (ev_rtc),
        .ev_pwrbtn(ev_pwrbtn),
        .ev_glock (ev_glock),
        .sts      (sts_w),
        .en       (en_w),
        .ctl      (ctl_w),
        .tmr      (tmr_w)
    );

    always_comb begin
        io_rdata = '0;
        if (io_hit) begin
            case (ofs_w)
                WIN_AW'(OFS_STS): io_rdata = {16'h0, sts_w};
                WIN_AW'(OFS_EN):  io_rdata = {16'h0, en_w};
                WIN_AW'(OFS_CTL): io_rdata = {16'h0, ctl_w};
                WIN_AW'(OFS_TMR): io_rdata = 32'(tmr_w);
                default:          io_rdata = '0;
            endcase
        end
    end

    assign sci     = |(sts_w & en_w & EVT_MASK);
    assign tmr_arm = en_w[BIT_TMR] & ~sts_w[BIT_TMR];
endmodule

// File: rtl/pm_evt_win_chk.sv
module pm_evt_win_chk
    import pm_evt_pkg::*;
#(
    parameter int TMR_BITS = 24,
    parameter int WIN_AW   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                io_wr,
    input logic                io_hit,
    input logic [15:0]         io_wdata,
    input logic [WIN_AW-1:0]   ofs,
    input logic                win_en,
    input logic                tmr_tick,
    input logic                ev_rtc,
    input logic                ev_pwrbtn,
    input logic                ev_glock,
    input logic                sci,
    input logic                tmr_arm,
    input logic [15:0]         sts,
    input logic [15:0]         en,
    input logic [TMR_BITS-1:0] tmr
);
    localparam logic [TMR_BITS-1:0] HALF_M1 = {1'b0, {(TMR_BITS-1){1'b1}}};

    p_hit_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_hit |-> win_en);

    p_pwr_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pwrbtn |=> sts[BIT_PWR]);

    p_clear_drops_sci_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_hit && ofs == WIN_AW'(OFS_STS) && io_wdata == 16'hFFFF &&
         !ev_rtc && !ev_pwrbtn && !ev_glock && !tmr_tick) |=> !sci);

    p_sci_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & EVT_MASK) == 16'h0) |-> !sci);

    p_timer_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick |=> (tmr == $past(tmr) + TMR_BITS'(1)));

    p_timer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_tick |=> $stable(tmr));

    p_overflow_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && tmr == HALF_M1) |=> (sts[BIT_TMR] && !tmr_arm));
endmodule

bind pm_evt_win pm_evt_win_chk #(.TMR_BITS(TMR_BITS), .WIN_AW(WIN_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .io_hit   (io_hit),
    .io_wdata (io_wdata),
    .ofs      (ofs_w),
    .win_en   (win_en_w),
    .tmr_tick (tmr_tick),
    .ev_rtc   (ev_rtc),
    .ev_pwrbtn(ev_pwrbtn),
    .ev_glock (ev_glock),
    .sci      (sci),
    .tmr_arm  (tmr_arm),
    .sts      (sts_w),
    .en       (en_w),
    .tmr      (tmr_w)
);

// File: tb/pm_evt_win_bench.sv
`timescale 1ns/1ps
module pm_evt_win_bench;
    localparam int TB_TMR = 8;
    localparam int HALF   = 1 << (TB_TMR - 1);
    localparam logic [15:0] BASE  = 16'hB000;
    localparam logic [15:0] A_STS = BASE + 16'h00;
    localparam logic [15:0] A_EN  = BASE + 16'h02;
    localparam logic [15:0] A_CTL = BASE + 16'h04;
    localparam logic [15:0] A_TMR = BASE + 16'h08;
    localparam logic [15:0] FEAT  = 16'h0521;

    // {ev rtc,pwr,glk[3], enable[16], exp status[16], exp sci, exp arm}
    localparam int NV = 9;
    localparam logic [36:0] VECS [NV] = '{
        {3'b000, 16'h0521, 16'h0000, 1'b0, 1'b1},
        {3'b010, 16'h0100, 16'h0100, 1'b1, 1'b0},
        {3'b010, 16'h0400, 16'h0100, 1'b0, 1'b0},
        {3'b100, 16'h0400, 16'h0400, 1'b1, 1'b0},
        {3'b001, 16'h0020, 16'h0020, 1'b1, 1'b0},
        {3'b101, 16'h0100, 16'h0420, 1'b0, 1'b0},
        {3'b111, 16'hFADE, 16'h0520, 1'b0, 1'b0},
        {3'b111, 16'hFFFF, 16'h0520, 1'b1, 1'b1},
        {3'b010, 16'h0001, 16'h0100, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_hit;
    logic        tmr_tick = 1'b0;
    logic        ev_rtc = 1'b0, ev_pwrbtn = 1'b0, ev_glock = 1'b0;
    logic        sci, tmr_arm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pm_evt_win #(.TMR_BITS(TB_TMR)) u_pm_evt_win (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk);
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [31:0] d);
        io_addr = a; #1; d = io_rdata;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk); {ev_rtc, ev_pwrbtn, ev_glock} = ev;
        @(posedge clk);
        @(negedge clk); {ev_rtc, ev_pwrbtn, ev_glock} = 3'b000;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tmr_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk); tmr_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            cfg_read(8'h40 + 8'(i), b); chk("R1 base byte", 32'(b), 32'h0);
        end
        cfg_read(8'h80, b); chk("R1 enable byte", 32'(b), 32'h0);
        io_addr = 16'h0000; #1;
        chk("R1 no decode", 32'(io_hit), 32'h0);
        chk("R1 sci", 32'(sci), 32'h0);
        chk("R1 tmr_arm", 32'(tmr_arm), 32'h0);

        // R12 fixed bytes, writes ignored
        cfg_write(8'h48, 8'hFF); cfg_write(8'hD2, 8'h00); cfg_write(8'h91, 8'h12);
        cfg_read(8'h48, b); chk("R12 0x48", 32'(b), 32'h01);
        cfg_read(8'h49, b); chk("R12 0x49", 32'(b), 32'h00);
        cfg_read(8'hD2, b); chk("R12 0xD2", 32'(b), 32'h90);
        cfg_read(8'h90, b); chk("R12 0x90", 32'(b), 32'hE1);
        cfg_read(8'h91, b); chk("R12 0x91", 32'(b), 32'hEE);

        // R2 base register (low bits junk, high word non-zero)
        cfg_write(8'h40, 8'h3F); cfg_write(8'h41, 8'hB0);
        cfg_write(8'h42, 8'h01); cfg_write(8'h43, 8'h00);
        cfg_read(8'h40, b); chk("R2 byte0 readback", 32'(b), 32'h3F);
        cfg_read(8'h42, b); chk("R2 byte2 readback", 32'(b), 32'h01);

        // R3 disabled window ignores writes
        io_addr = A_EN; #1; chk("R3 hit while off", 32'(io_hit), 32'h0);
        io_write(A_EN, 16'hFFFF);
        io_read(A_EN, r); chk("R3 rdata while off", r, 32'h0);
        cfg_write(8'h80, 8'hFF);
        cfg_read(8'h80, b); chk("R3 enable byte", 32'(b), 32'h01);
        io_read(A_EN, r); chk("R3 write dropped", r, 32'h0);

        // R2 decode edges
        io_addr = BASE;          #1; chk("R2 hit low edge", 32'(io_hit), 32'h1);
        io_addr = BASE + 16'h3E; #1; chk("R2 hit high edge", 32'(io_hit), 32'h1);
        io_addr = BASE - 16'h2;  #1; chk("R2 below", 32'(io_hit), 32'h0);
        io_addr = BASE + 16'h40; #1; chk("R2 above", 32'(io_hit), 32'h0);

        // R6 enable mask, R11 control
        io_write(A_EN, 16'hFFFF);
        io_read(A_EN, r); chk("R6 enable mask", r, 32'(FEAT));
        io_write(A_CTL, 16'hA5C3);
        io_read(A_CTL, r); chk("R11 control", r, 32'h0000A5C3);

        // R4 R7 R10 table
        for (int v = 0; v < NV; v++) begin
            io_write(A_STS, 16'hFFFF);
            io_write(A_EN, VECS[v][33:18]);
            pulse(VECS[v][36:34]);
            io_read(A_STS, r); chk($sformatf("R4 status vec%0d", v), r, 32'(VECS[v][17:2]));
            io_read(A_EN, r);  chk($sformatf("R6 enable vec%0d", v), r, 32'(VECS[v][33:18] & FEAT));
            chk($sformatf("R7 sci vec%0d", v), 32'(sci), 32'(VECS[v][1]));
            chk($sformatf("R10 arm vec%0d", v), 32'(tmr_arm), 32'(VECS[v][0]));
        end

        // R5 write-one-to-clear
        io_write(A_EN, 16'h0100);
        chk("R5 sci pending", 32'(sci), 32'h1);
        io_write(A_STS, 16'h0000);
        chk("R5 zero write keeps sci", 32'(sci), 32'h1);
        io_read(A_STS, r); chk("R5 zero write keeps status", r, 32'h0100);
        io_write(A_STS, 16'h0100);
        chk("R7 sci falls next cycle", 32'(sci), 32'h0);
        @(negedge clk); ev_pwrbtn = 1'b1; io_wr = 1'b1; io_addr = A_STS; io_wdata = 16'h0100;
        @(posedge clk);
        @(negedge clk); ev_pwrbtn = 1'b0; io_wr = 1'b0;
        io_read(A_STS, r); chk("R5 set wins", r, 32'h0100);

        // R8 R9 R10 timer
        io_write(A_STS, 16'hFFFF);
        io_write(A_EN, 16'h0001);
        chk("R10 armed", 32'(tmr_arm), 32'h1);
        io_read(A_TMR, r); chk("R8 timer idle", r, 32'h0);
        ticks(HALF - 1);
        io_read(A_TMR, r); chk("R8 timer count", r, 32'(HALF - 1));
        io_read(A_STS, r); chk("R9 no early set", r, 32'h0);
        ticks(1);
        io_read(A_STS, r); chk("R9 rising set", r, 32'h1);
        chk("R10 disarmed", 32'(tmr_arm), 32'h0);
        chk("R7 timer sci", 32'(sci), 32'h1);
        io_read(A_TMR, r); chk("R8 timer half", r, 32'(HALF));
        io_write(A_STS, 16'h0001);
        chk("R10 rearmed", 32'(tmr_arm), 32'h1);
        ticks(HALF - 1);
        io_read(A_STS, r); chk("R9 quiet before wrap", r, 32'h0);
        ticks(1);
        io_read(A_STS, r); chk("R9 falling set", r, 32'h1);
        io_read(A_TMR, r); chk("R8 timer wrap", r, 32'h0);
        io_write(A_TMR, 16'h1234);
        io_read(A_TMR, r); chk("R8 write ignored", r, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule